// File: doc/BRIEF.md
# Set/Clear Flag Register Bank

A word-addressed register bank on a plain 32-bit read/write bus. It holds a board identification word, an LED output register, a flash write-protect control and two 32-bit flag registers. Each flag register has two addresses. Writing the set address ORs the write data into the flags, and a read at that address returns the current value. Writing the clear address removes every bit that is 1 in the write data. Software can therefore change single flag bits without a read-modify-write sequence.

Three board status inputs read back at fixed bit positions: card present, card write-protect and the master-site strap. The volatile flag register clears on either reset. The persistent flag register clears only on the power-on reset, so it keeps its value through a warm reset. Reads return data one cycle after the request. Only full-word accesses exist, and the two low address bits are ignored.

Top module: `flagbank_regs`

## Requirements
- R1: When reset ends, led_out is 0, flash_wp_n is 0, rd_valid is 0 and both flag registers read 0.
- R2: A read of byte offset 0x030 returns the volatile flags, and a write there ORs req_wdata into them.
- R3: A write to offset 0x034 clears each volatile flag bit whose write-data bit is 1 and leaves the others alone. A read of 0x034 returns 0.
- R4: A write of all ones to a clear address, followed by a write of value V to the matching set address, leaves exactly V in that flag register.
- R5: The persistent flags use the same scheme: offset 0x038 reads them and sets bits, and offset 0x03C clears bits (and reads 0).
- R6: The persistent flags keep their value while rst_n is low, and only por_n low clears them. Either reset clears the volatile flags, the LED register and the flash control.
- R7: Offset 0x000 reads board_code in bits 27:16, with every other bit 0. Writes to it have no effect.
- R8: Offset 0x008 bits 7:0 drive led_out and read back the last value written. Bits 31:8 read 0.
- R9: Offset 0x048 reads card_present in bit 0 and card_wprot in bit 1. Offset 0x060 reads master_site_sel in bit 14 (1 = second site, 0 = first site). All other bits of both words read 0.
- R10: Offset 0x04C bit 0 is a read/write control that drives flash_wp_n directly (0 = write-protected). Its other bits read 0.
- R11: A read request in cycle N gives rd_valid = 1 and its data in cycle N+1. In a cycle after a non-read, rd_valid is 0 and rd_data is 0.
- R12: Reads of offsets with no register return 0. Writes to read-only or unmapped offsets change no register.
- R13: Bus requests made while rst_n is low are ignored, including writes to the persistent flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Warm reset, asynchronous, active low |
| por_n | input | 1 | Power-on reset, asynchronous, active low; resets everything |
| req_valid | input | 1 | Bus request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte address; bits 1:0 are ignored |
| req_wdata | input | DATA_W (32) | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after the read request) |
| rd_data | output | DATA_W (32) | Read data; 0 when rd_valid is low |
| board_code | input | CODE_W (12) | Board identification code |
| card_present | input | 1 | Card detect status |
| card_wprot | input | 1 | Card write-protect status |
| master_site_sel | input | 1 | Master daughterboard site strap |
| led_out | output | LED_N (8) | LED drive outputs |
| flash_wp_n | output | 1 | Flash write-protect control, active low |

## Verification
A warm reset and a bus write to the persistent flag set address can fall in the same cycle. The bench provokes this by lowering rst_n on the same falling edge where it presents a write of a new pattern to 0x038, and holds both for two clock edges. After reset it reads back the persistent flags. The result passes only if the flags still hold the value from before reset. In the same step the volatile flags, the LEDs and the flash control must all read zero.

// File: rtl/flagbank_pkg.sv
package flagbank_pkg;

    localparam logic [11:0] OFF_ID      = 12'h000;
    localparam logic [11:0] OFF_LED     = 12'h008;
    localparam logic [11:0] OFF_VSET    = 12'h030;
    localparam logic [11:0] OFF_VCLR    = 12'h034;
    localparam logic [11:0] OFF_NVSET   = 12'h038;
    localparam logic [11:0] OFF_NVCLR   = 12'h03C;
    localparam logic [11:0] OFF_CARD    = 12'h048;
    localparam logic [11:0] OFF_FLASH   = 12'h04C;
    localparam logic [11:0] OFF_MISC    = 12'h060;

    localparam int unsigned ID_LSB      = 16;
    localparam int unsigned MASTER_BIT  = 14;
    localparam int unsigned NUM_FLAGREG = 2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ID,
        SEL_LED,
        SEL_VFLAG,
        SEL_NVFLAG,
        SEL_CARD,
        SEL_FLASH,
        SEL_MISC
    } reg_sel_e;

endpackage

// File: rtl/flagbank_decode.sv
module flagbank_decode
    import flagbank_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              acc_i,
    input  logic              wr_i,
    output reg_sel_e          rd_sel_o,
    output logic              v_set_o,
    output logic              v_clr_o,
    output logic              nv_set_o,
    output logic              nv_clr_o,
    output logic              led_wr_o,
    output logic              fwp_wr_o
);

    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              unused_lo;

    assign word      = addr_i[ADDR_W-1:2];
    assign unused_lo = ^addr_i[1:0];

    function automatic logic hit(input logic [WORD_W-1:0] w, input logic [11:0] off);
        return w == WORD_W'(off >> 2);
    endfunction

    always_comb begin
        rd_sel_o = SEL_NONE;
        if (acc_i && !wr_i) begin
            if (hit(word, OFF_ID))         rd_sel_o = SEL_ID;
            else if (hit(word, OFF_LED))   rd_sel_o = SEL_LED;
            else if (hit(word, OFF_VSET))  rd_sel_o = SEL_VFLAG;
            else if (hit(word, OFF_NVSET)) rd_sel_o = SEL_NVFLAG;
            else if (hit(word, OFF_CARD))  rd_sel_o = SEL_CARD;
            else if (hit(word, OFF_FLASH)) rd_sel_o = SEL_FLASH;
            else if (hit(word, OFF_MISC))  rd_sel_o = SEL_MISC;
        end
    end

    always_comb begin
        v_set_o  = acc_i && wr_i && hit(word, OFF_VSET);
        v_clr_o  = acc_i && wr_i && hit(word, OFF_VCLR);
        nv_set_o = acc_i && wr_i && hit(word, OFF_NVSET);
        nv_clr_o = acc_i && wr_i && hit(word, OFF_NVCLR);
        led_wr_o = acc_i && wr_i && hit(word, OFF_LED);
        fwp_wr_o = acc_i && wr_i && hit(word, OFF_FLASH);
    end

endmodule

// File: rtl/flagbank_flag_reg.sv
module flagbank_flag_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_ni,
    input  logic         set_i,
    input  logic         clr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] bits;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.bits = st_q.bits | wdata_i;
        end else if (clr_i) begin
            st_d.bits = st_q.bits & ~wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.bits;

    p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_ni)
        set_i |=> ((q_o & $past(wdata_i)) == $past(wdata_i)));

    p_flag_clr_r3: assert property (@(posedge clk) disable iff (!rst_ni)
        clr_i |=> ((q_o & $past(wdata_i)) == '0));

    p_flag_keep_r5: assert property (@(posedge clk) disable iff (!rst_ni)
        (!set_i && !clr_i) |=> $stable(q_o));

    p_flag_onehot_r12: assert property (@(posedge clk) disable iff (!rst_ni)
        $onehot0({set_i, clr_i}));

endmodule

// File: rtl/flagbank_rd_mux.sv
module flagbank_rd_mux
    import flagbank_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LED_N  = 8,
    parameter int unsigned CODE_W = 12
) (
    input  reg_sel_e          sel_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [LED_N-1:0]  led_i,
    input  logic [DATA_W-1:0] vflag_i,
    input  logic [DATA_W-1:0] nvflag_i,
    input  logic              card_present_i,
    input  logic              card_wprot_i,
    input  logic              fwp_i,
    input  logic              master_i,
    output logic [DATA_W-1:0] rdata_o
);

    always_comb begin
        rdata_o = '0;
        unique case (sel_i)
            SEL_ID:     rdata_o[ID_LSB +: CODE_W] = code_i;
            SEL_LED:    rdata_o[LED_N-1:0] = led_i;
            SEL_VFLAG:  rdata_o = vflag_i;
            SEL_NVFLAG: rdata_o = nvflag_i;
            SEL_CARD:   rdata_o[1:0] = {card_wprot_i, card_present_i};
            SEL_FLASH:  rdata_o[0] = fwp_i;
            SEL_MISC:   rdata_o[MASTER_BIT] = master_i;
            default:    rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/flagbank_regs.sv
module flagbank_regs
    import flagbank_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LED_N  = 8,
    parameter int unsigned CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CODE_W-1:0] board_code,
    input  logic              card_present,
    input  logic              card_wprot,
    input  logic              master_site_sel,
    output logic [LED_N-1:0]  led_out,
    output logic              flash_wp_n
);

    typedef struct packed {
        logic [LED_N-1:0]  led;
        logic              fwp;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic              wrst_n;
    logic              acc;
    logic              rd_stb;
    reg_sel_e          rd_sel;
    logic              led_wr, fwp_wr;
    logic [DATA_W-1:0] mux_data;

    logic [NUM_FLAGREG-1:0] f_set, f_clr, f_rst_n;
    logic [DATA_W-1:0]      f_q [NUM_FLAGREG];

    assign wrst_n = rst_n & por_n;
    assign acc    = req_valid & rst_n;
    assign rd_stb = acc & ~req_write;

    flagbank_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i   (req_addr),
        .acc_i    (acc),
        .wr_i     (req_write),
        .rd_sel_o (rd_sel),
        .v_set_o  (f_set[0]),
        .v_clr_o  (f_clr[0]),
        .nv_set_o (f_set[1]),
        .nv_clr_o (f_clr[1]),
        .led_wr_o (led_wr),
        .fwp_wr_o (fwp_wr)
    );

    // Index 0: volatile (either reset); index 1: persistent (power-on only)
    assign f_rst_n[0] = wrst_n;
    assign f_rst_n[1] = por_n;

    for (genvar gi = 0; gi < NUM_FLAGREG; gi++) begin : g_flag
        flagbank_flag_reg #(.W(DATA_W)) u_flag (
            .clk     (clk),
            .rst_ni  (f_rst_n[gi]),
            .set_i   (f_set[gi]),
            .clr_i   (f_clr[gi]),
            .wdata_i (req_wdata),
            .q_o     (f_q[gi])
        );
    end

    flagbank_rd_mux #(
        .DATA_W (DATA_W),
        .LED_N  (LED_N),
        .CODE_W (CODE_W)
    ) u_rd_mux (
        .sel_i          (rd_sel),
        .code_i         (board_code),
        .led_i          (st_q.led),
        .vflag_i        (f_q[0]),
        .nvflag_i       (f_q[1]),
        .card_present_i (card_present),
        .card_wprot_i   (card_wprot),
        .fwp_i          (st_q.fwp),
        .master_i       (master_site_sel),
        .rdata_o        (mux_data)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd_stb;
        st_d.rdata  = rd_stb ? mux_data : '0;
        if (led_wr) begin
            st_d.led = req_wdata[LED_N-1:0];
        end
        if (fwp_wr) begin
            st_d.fwp = req_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge wrst_n) begin
        if (!wrst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid   = st_q.rvalid;
    assign rd_data    = st_q.rdata;
    assign led_out    = st_q.led;
    assign flash_wp_n = st_q.fwp;

    p_rd_latency_r11: assert property (@(posedge clk) disable iff (!wrst_n)
        rd_stb |=> rd_valid);

    p_rd_idle_r11: assert property (@(posedge clk) disable iff (!wrst_n)
        !rd_stb |=> (!rd_valid && rd_data == '0));

    p_id_word_r7: assert property (@(posedge clk) disable iff (!wrst_n)
        (rd_stb && rd_sel == SEL_ID) |=> (rd_data[ID_LSB +: CODE_W] == $past(board_code)));

    p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!wrst_n)
        (rd_stb && rd_sel == SEL_NONE) |=> (rd_data == '0));

    p_led_hold_r12: assert property (@(posedge clk) disable iff (!wrst_n)
        !led_wr |=> $stable(led_out));

    p_nv_warm_r6: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> $stable(f_q[1]));

endmodule

// File: tb/flagbank_regs_test.sv
module flagbank_regs_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, por_n;
    logic        req_valid, req_write;
    logic [11:0] req_addr;
    logic [31:0] req_wdata;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [11:0] board_code;
    logic        card_present, card_wprot, master_site_sel;
    logic [7:0]  led_out;
    logic        flash_wp_n;

    int checks = 0;
    int failures = 0;

    logic [31:0] m_vf, m_nv;
    logic [7:0]  m_led;
    logic        m_fwp;

    always #(CLK_PERIOD/2) clk = ~clk;

    flagbank_regs uut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .board_code(board_code), .card_present(card_present),
        .card_wprot(card_wprot), .master_site_sel(master_site_sel),
        .led_out(led_out), .flash_wp_n(flash_wp_n)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        logic [31:0] r = '0;
        case ({a[11:2], 2'b00})
            12'h000: r[27:16] = board_code;
            12'h008: r[7:0]   = m_led;
            12'h030: r        = m_vf;
            12'h038: r        = m_nv;
            12'h048: r[1:0]   = {card_wprot, card_present};
            12'h04C: r[0]     = m_fwp;
            12'h060: r[14]    = master_site_sel;
            default: r        = '0;
        endcase
        return r;
    endfunction

    function automatic logic writable(input logic [11:0] a);
        case ({a[11:2], 2'b00})
            12'h008, 12'h030, 12'h034, 12'h038, 12'h03C, 12'h04C: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        case ({a[11:2], 2'b00})
            12'h008: m_led = d[7:0];
            12'h030: m_vf  = m_vf | d;
            12'h034: m_vf  = m_vf & ~d;
            12'h038: m_nv  = m_nv | d;
            12'h03C: m_nv  = m_nv & ~d;
            12'h04C: m_fwp = d[0];
            default: ;
        endcase
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        model_write(a, d);
    endtask

    task automatic read_check(input logic [11:0] a, input string tag);
        logic [31:0] e;
        e = exp_read(a);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 32'h5A5A_A5A5;
        @(negedge clk);
        req_valid = 1'b0;
        check(rd_valid === 1'b1 && rd_data === e, tag, rd_data, e);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog: got %h expected %h", 32'h0, 32'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; por_n = 1'b0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        board_code = 12'hA5C; card_present = 1'b0; card_wprot = 1'b0; master_site_sel = 1'b0;
        m_vf = '0; m_nv = '0; m_led = '0; m_fwp = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(led_out === 8'h00, "R1 led_out", {24'h0, led_out}, 32'h0);
        check(flash_wp_n === 1'b0, "R1 flash_wp_n", {31'h0, flash_wp_n}, 32'h0);
        check(rd_valid === 1'b0, "R1 rd_valid", {31'h0, rd_valid}, 32'h0);
        read_check(12'h030, "R1 vflags");
        read_check(12'h038, "R1 nvflags");

        // R7 ID word, writes ignored
        read_check(12'h000, "R7 id");
        bus_write(12'h000, 32'hFFFF_FFFF);
        read_check(12'h000, "R7 id after write");
        board_code = 12'h3F1;
        read_check(12'h002, "R7 id other code, low addr bits ignored");

        // R2 set bits one by one
        for (int i = 0; i < 32; i++) begin
            bus_write(12'h030, 32'h1 << i);
            read_check(12'h030, "R2 set bit");
        end
        // R3 clear bits one by one
        read_check(12'h034, "R3 clear alias reads zero");
        for (int i = 0; i < 32; i += 3) begin
            bus_write(12'h034, 32'h1 << i);
            read_check(12'h030, "R3 clear bit");
        end
        // R4 clear-all then set, volatile and persistent
        for (int i = 1; i < 20; i++) begin
            logic [31:0] pat;
            pat = i * 32'h9E37_79B9;
            bus_write(12'h034, 32'hFFFF_FFFF);
            bus_write(12'h030, pat);
            check(exp_read(12'h030) === pat, "R4 model", exp_read(12'h030), pat);
            read_check(12'h030, "R4 vflags exact");
            bus_write(12'h03C, 32'hFFFF_FFFF);
            bus_write(12'h038, ~pat);
            read_check(12'h038, "R4 nvflags exact");
        end
        // R5 persistent flags set/clear
        bus_write(12'h03C, 32'hFFFF_FFFF);
        for (int i = 0; i < 32; i += 5) begin
            bus_write(12'h038, 32'h3 << i);
            read_check(12'h038, "R5 nv set");
        end
        bus_write(12'h03C, 32'h0F0F_0F0F);
        read_check(12'h038, "R5 nv clear");
        read_check(12'h03C, "R5 nv clear alias reads zero");

        // R8 LED exhaustive
        for (int v = 0; v < 256; v++) begin
            bus_write(12'h008, {24'hABCDEF, v[7:0]});
            check(led_out === v[7:0], "R8 led_out", {24'h0, led_out}, {24'h0, v[7:0]});
            read_check(12'h008, "R8 led readback");
        end

        // R10 flash write-protect control
        bus_write(12'h04C, 32'h0000_0001);
        check(flash_wp_n === 1'b1, "R10 flash_wp_n high", {31'h0, flash_wp_n}, 32'h1);
        read_check(12'h04C, "R10 readback");
        bus_write(12'h04C, 32'hFFFF_FFFE);
        check(flash_wp_n === 1'b0, "R10 flash_wp_n low", {31'h0, flash_wp_n}, 32'h0);
        read_check(12'h04C, "R10 readback low");
        bus_write(12'h04C, 32'h0000_0001);

        // R9 status inputs, all combinations
        for (int c = 0; c < 8; c++) begin
            card_present = c[0]; card_wprot = c[1]; master_site_sel = c[2];
            read_check(12'h048, "R9 card status");
            read_check(12'h060, "R9 master site");
        end

        // R11 latency and idle zero; back-to-back reads
        req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h008;
        @(negedge clk);
        check(rd_valid === 1'b1 && rd_data === exp_read(12'h008), "R11 first of pair", rd_data, exp_read(12'h008));
        req_addr = 12'h060;
        @(negedge clk);
        req_valid = 1'b0;
        check(rd_valid === 1'b1 && rd_data === exp_read(12'h060), "R11 second of pair", rd_data, exp_read(12'h060));
        @(negedge clk);
        check(rd_valid === 1'b0 && rd_data === 32'h0, "R11 idle", rd_data, 32'h0);
        bus_write(12'h030, 32'h1);
        check(rd_valid === 1'b0 && rd_data === 32'h0, "R11 after write", rd_data, 32'h0);

        // R12 write ones to every non-writable offset, then sweep all offsets
        for (int w = 0; w < 64; w++) begin
            if (!writable(12'(w * 4))) bus_write(12'(w * 4), 32'hFFFF_FFFF);
        end
        check(led_out === m_led, "R12 led unchanged", {24'h0, led_out}, {24'h0, m_led});
        for (int w = 0; w < 64; w++) begin
            read_check(12'(w * 4), "R12 offset sweep");
        end

        // R6 R13: warm reset coincides with a persistent-flag write
        bus_write(12'h034, 32'hFFFF_FFFF);
        bus_write(12'h030, 32'h0000_1234);
        bus_write(12'h03C, 32'hFFFF_FFFF);
        bus_write(12'h038, 32'hCAFE_0001);
        bus_write(12'h008, 32'h0000_003C);
        rst_n = 1'b0;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h038; req_wdata = 32'h00FF_FF00;
        @(negedge clk);
        @(negedge clk);
        check(led_out === 8'h00, "R6 led cleared in warm reset", {24'h0, led_out}, 32'h0);
        req_valid = 1'b0; req_write = 1'b0;
        rst_n = 1'b1;
        m_vf = '0; m_led = '0; m_fwp = 1'b0;
        @(negedge clk);
        check(flash_wp_n === 1'b0, "R6 flash cleared", {31'h0, flash_wp_n}, 32'h0);
        read_check(12'h038, "R6 R13 nvflags survive warm reset");
        read_check(12'h030, "R6 vflags cleared");
        read_check(12'h008, "R6 led readback cleared");
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        m_nv = '0;
        @(negedge clk);
        read_check(12'h038, "R6 nvflags cleared by power-on reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule